// File: doc/BRIEF.md
# Per-pixel blinking LCD segment driver

This block controls one multiplexed LCD segment pin that is shared by four commons, so up to four pixels hang on the pin. It holds the four pixel bits, one for each common. It also holds a four-bit mask that selects which of those pixels blink, and a single rate bit that picks a blink period of one second (1 Hz) or two seconds (0.5 Hz). The common-scan logic receives the resulting four-bit pattern on `seg_out`. During the off half of the blink, the pixels named by the mask are cleared. Every other pixel always follows its stored bit.

The timebase is a 1 kHz single-cycle enable, `tick_1k`. A phase state machine has two states, `PH_ON` and `PH_OFF`. The transition `HALF_DONE` toggles between them when the tick counter completes a half-period. The transition `RESTART` forces `PH_ON` and clears the counter when a write changes the rate bit. Software loads the block through a write-only bus made of an enable, a 2-bit address and a byte. The pixel field sits either in byte bits 3:0 or in byte bits 7:4, depending on the parameter `SEG_FIELD_HI`.

Top module: `seg_blink_ctrl`

## Requirements
- R1: Synchronous active-high `rst` clears the pixel bits, the mask, the rate bit and the tick counter, and puts the phase in on. While in reset and right after it, `seg_out` is 4'h0.
- R2: A write to address 0 loads the pixel bits from byte bits 7:4 when `SEG_FIELD_HI`=1, or from bits 3:0 when it is 0. The other nibble has no effect. `seg_out` shows the new value from the clock edge that takes the write.
- R3: A pixel whose mask bit (address 1, byte bits 3:0, bit i for common i) is 0 always equals its stored bit. With the mask at 4'h0, no pixel ever changes without a write.
- R4: While the phase is off, every pixel whose mask bit is 1 reads 0, including a mask bit that is written during the off phase.
- R5: With the rate bit (address 2, byte bit 0) at 0, the phase toggles on the 500th tick of each half-period (1 Hz blink).
- R6: With the rate bit at 1, the phase toggles on the 1000th tick of each half-period (0.5 Hz blink).
- R7: A write that changes the rate bit sends the phase to on and restarts the half-period count from zero. A write of the same value leaves the phase and the count untouched.
- R8: A bus cycle with `wr_en` low, or a write to address 3, changes no stored state.
- R9: Clock cycles without `tick_1k` neither advance the count nor change the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_1k | input | 1 | 1 kHz single-cycle enable for the blink timebase |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address: 0 pixels, 1 mask, 2 rate |
| wr_data | input | 8 | Write data byte |
| seg_out | output | 4 | Effective pixel pattern, bit i for common i |

## Verification
The bench builds the block with `SEG_FIELD_HI`=1. This places the pixel field in the upper nibble, so filling the lower nibble with ones checks that the unused half of the byte is ignored. The tick limits stay at their defaults of 500 and 1000. Because the bench drives the tick on every cycle, it can step to the 499th and 500th ticks, and to the 999th and 1000th, to observe each toggle edge exactly. With these limits it can also restart the count partway through a half-period.

// File: rtl/seg_blink_pkg.sv
package seg_blink_pkg;

    localparam int NCOM   = 4;
    localparam int BUS_W  = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADR_PIX  = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_MASK = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_RATE = 2'd2;

    typedef enum logic [0:0] {
        PH_ON  = 1'b0,
        PH_OFF = 1'b1
    } blink_phase_t;

endpackage

// File: rtl/seg_blink_regs.sv
module seg_blink_regs
    import seg_blink_pkg::*;
#(
    parameter bit SEG_FIELD_HI = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    output logic [NCOM-1:0]   pix_q,
    output logic [NCOM-1:0]   mask_q,
    output logic              rate_q,
    output logic              rate_chg
);

    localparam int FIELD_LO = SEG_FIELD_HI ? (BUS_W - NCOM) : 0;

    logic [NCOM-1:0] pix_field;
    logic            wr_pix;
    logic            wr_mask;
    logic            wr_rate;
    logic            unused_bits;

    generate
        if (SEG_FIELD_HI) begin : g_field_hi
            assign pix_field = wr_data[FIELD_LO +: NCOM];
        end else begin : g_field_lo
            assign pix_field = wr_data[NCOM-1:0];
        end
    endgenerate

    assign unused_bits = ^wr_data;

    always_comb begin
        wr_pix  = wr_en && (wr_addr == ADR_PIX);
        wr_mask = wr_en && (wr_addr == ADR_MASK);
        wr_rate = wr_en && (wr_addr == ADR_RATE);
    end

    assign rate_chg = wr_rate && (wr_data[0] != rate_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_q  <= '0;
            mask_q <= '0;
            rate_q <= 1'b0;
        end else begin
            if (wr_pix) begin
                pix_q <= pix_field;
            end
            if (wr_mask) begin
                mask_q <= wr_data[NCOM-1:0];
            end
            if (wr_rate) begin
                rate_q <= wr_data[0];
            end
        end
    end

endmodule

// File: rtl/seg_blink_timer.sv
module seg_blink_timer
    import seg_blink_pkg::*;
#(
    parameter int TICKS_FAST = 500,
    parameter int TICKS_SLOW = 1000,
    parameter int CNT_W      = $clog2((TICKS_SLOW > TICKS_FAST) ? TICKS_SLOW : TICKS_FAST)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             rate_sel,
    input  logic             restart,
    output logic             phase_on,
    output logic [CNT_W-1:0] cnt_q
);

    localparam logic [CNT_W-1:0] LIM_FAST = CNT_W'(TICKS_FAST - 1);
    localparam logic [CNT_W-1:0] LIM_SLOW = CNT_W'(TICKS_SLOW - 1);

    blink_phase_t     state_q;
    blink_phase_t     state_d;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] lim;
    logic             half_done;

    assign lim       = rate_sel ? LIM_SLOW : LIM_FAST;
    assign half_done = tick && (cnt_q == lim);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_ON;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (restart) begin
            state_d = PH_ON;
            cnt_d   = '0;
        end else if (half_done) begin
            cnt_d = '0;
            unique case (state_q)
                PH_ON:   state_d = PH_OFF;
                PH_OFF:  state_d = PH_ON;
                default: state_d = PH_ON;
            endcase
        end else if (tick) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            PH_ON:   phase_on = 1'b1;
            PH_OFF:  phase_on = 1'b0;
            default: phase_on = 1'b1;
        endcase
    end

endmodule

// File: rtl/seg_blink_mux.sv
module seg_blink_mux
    import seg_blink_pkg::*;
(
    input  logic [NCOM-1:0] pix,
    input  logic [NCOM-1:0] mask,
    input  logic            phase_on,
    output logic [NCOM-1:0] seg
);

    generate
        for (genvar i = 0; i < NCOM; i++) begin : g_com
            assign seg[i] = pix[i] & ~(mask[i] & ~phase_on);
        end
    endgenerate

endmodule

// File: rtl/seg_blink_ctrl.sv
module seg_blink_ctrl
    import seg_blink_pkg::*;
#(
    parameter bit SEG_FIELD_HI = 1'b1,
    parameter int TICKS_FAST   = 500,
    parameter int TICKS_SLOW   = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1k,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    output logic [NCOM-1:0]   seg_out
);

    localparam int CNT_W = $clog2((TICKS_SLOW > TICKS_FAST) ? TICKS_SLOW : TICKS_FAST);

    logic [NCOM-1:0]  pix_q;
    logic [NCOM-1:0]  mask_q;
    logic             rate_q;
    logic             rate_chg;
    logic             phase_on;
    logic [CNT_W-1:0] cnt_q;

    seg_blink_regs #(
        .SEG_FIELD_HI (SEG_FIELD_HI)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .pix_q    (pix_q),
        .mask_q   (mask_q),
        .rate_q   (rate_q),
        .rate_chg (rate_chg)
    );

    seg_blink_timer #(
        .TICKS_FAST (TICKS_FAST),
        .TICKS_SLOW (TICKS_SLOW),
        .CNT_W      (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_1k),
        .rate_sel (rate_q),
        .restart  (rate_chg),
        .phase_on (phase_on),
        .cnt_q    (cnt_q)
    );

    seg_blink_mux u_mux (
        .pix      (pix_q),
        .mask     (mask_q),
        .phase_on (phase_on),
        .seg      (seg_out)
    );

endmodule

// File: rtl/seg_blink_chk.sv
module seg_blink_chk
    import seg_blink_pkg::*;
#(
    parameter int TICKS_FAST = 500,
    parameter int TICKS_SLOW = 1000,
    parameter int CNT_W      = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             rate_q,
    input logic             rate_chg,
    input logic             phase_on,
    input logic [CNT_W-1:0] cnt_q,
    input logic [NCOM-1:0]  pix_q,
    input logic [NCOM-1:0]  mask_q,
    input logic [NCOM-1:0]  seg_out
);

    AST_RESET_STATE: assert property (@(posedge clk) $past(rst) |-> (phase_on && cnt_q == '0 && seg_out == '0)); // R1

    AST_UNMASKED_STEADY: assert property (@(posedge clk) disable iff (rst) ((seg_out & ~mask_q) == (pix_q & ~mask_q))); // R3

    AST_OFF_FORCED: assert property (@(posedge clk) disable iff (rst) !phase_on |-> ((seg_out & mask_q) == '0)); // R4

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst) (32'(cnt_q) < (rate_q ? TICKS_SLOW : TICKS_FAST))); // R6

    AST_RATE_RESTART: assert property (@(posedge clk) disable iff (rst) rate_chg |=> (phase_on && cnt_q == '0)); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) (!tick && !rate_chg) |=> ($stable(phase_on) && $stable(cnt_q))); // R9

endmodule

bind seg_blink_ctrl seg_blink_chk #(
    .TICKS_FAST (TICKS_FAST),
    .TICKS_SLOW (TICKS_SLOW),
    .CNT_W      (CNT_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick_1k),
    .rate_q   (rate_q),
    .rate_chg (rate_chg),
    .phase_on (phase_on),
    .cnt_q    (cnt_q),
    .pix_q    (pix_q),
    .mask_q   (mask_q),
    .seg_out  (seg_out)
);

// File: tb/test_seg_blink_ctrl.sv
module test_seg_blink_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1k = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [3:0] seg_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    seg_blink_ctrl #(
        .SEG_FIELD_HI (1'b1),
        .TICKS_FAST   (500),
        .TICKS_SLOW   (1000)
    ) i_seg_blink_ctrl (
        .clk     (clk),
        .rst     (rst),
        .tick_1k (tick_1k),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .seg_out (seg_out)
    );

    task automatic check(input string req, input logic [3:0] exp);
        total++;
        if (seg_out !== exp) begin
            bad++;
            $display("FAIL %s: seg_out=%h expected=%h", req, seg_out, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic en = 1'b1);
        @(negedge clk);
        wr_en   = en;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic give_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick_1k = 1'b1;
        end
        @(negedge clk);
        tick_1k = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        idle(3);
        check("R1 in reset", 4'h0);
        rst = 1'b0;
        idle(1);
        check("R1 after reset", 4'h0);
    endtask

    task automatic t_data;
        bus_write(2'd0, 8'hA5);
        check("R2 upper nibble", 4'hA);
        bus_write(2'd0, 8'h0F);
        check("R2 lower nibble ignored", 4'h0);
        bus_write(2'd0, 8'hF0);
        check("R2 all pixels", 4'hF);
    endtask

    task automatic t_ignore;
        bus_write(2'd0, 8'h30, 1'b0);
        check("R8 wr_en low", 4'hF);
        bus_write(2'd3, 8'h30);
        check("R8 address 3", 4'hF);
        bus_write(2'd1, 8'h0F, 1'b0);
        give_ticks(500);
        check("R8 mask not loaded", 4'hF);
    endtask

    // phase is now off (500 ticks given above), mask still 0
    task automatic t_fast;
        check("R3 mask zero steady in off phase", 4'hF);
        bus_write(2'd1, 8'h05);
        check("R4 mask written during off", 4'hA);
        give_ticks(500);
        check("R5 back on after 500", 4'hF);
        give_ticks(499);
        check("R5 still on at 499", 4'hF);
        give_ticks(1);
        check("R5 off at 500", 4'hA);
        idle(40);
        check("R9 no tick holds off", 4'hA);
        give_ticks(499);
        check("R9 idle did not advance", 4'hA);
        give_ticks(1);
        check("R5 on again", 4'hF);
    endtask

    task automatic t_slow;
        give_ticks(500);
        check("R4 off before rate change", 4'hA);
        bus_write(2'd2, 8'h01);
        check("R7 rate change forces on", 4'hF);
        bus_write(2'd1, 8'h0C);
        give_ticks(999);
        check("R6 still on at 999", 4'hF);
        give_ticks(1);
        check("R6 off at 1000", 4'h3);
        bus_write(2'd2, 8'h01);
        check("R7 same rate keeps off", 4'h3);
        give_ticks(1000);
        check("R6 on after 1000", 4'hF);
    endtask

    task automatic t_restart;
        give_ticks(300);
        bus_write(2'd2, 8'h00);
        check("R7 restart on", 4'hF);
        give_ticks(499);
        check("R7 count restarted", 4'hF);
        give_ticks(1);
        check("R7 fast toggle after restart", 4'h3);
    endtask

    task automatic t_reset_mid;
        @(negedge clk);
        rst = 1'b1;
        idle(2);
        check("R1 reset mid-run", 4'h0);
        rst = 1'b0;
        bus_write(2'd0, 8'hF0);
        bus_write(2'd1, 8'h0F);
        check("R1 phase on after reset", 4'hF);
        give_ticks(499);
        check("R1 counter cleared", 4'hF);
        give_ticks(1);
        check("R1 toggle at 500 after reset", 4'h0);
    endtask

    initial begin
        t_reset();
        t_data();
        t_ignore();
        t_fast();
        t_slow();
        t_restart();
        t_reset_mid();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule